// File: doc/BRIEF.md
# Saturating Alarm Event Counters with Masked Interrupt

This block sits behind the line decoder and framer of a T1 receiver. It keeps a tally of error events so the host does not have to service each one. Three counters run on their own: one for bipolar violations, one for framing and out-of-frame errors, and one for errored superframes. Each counter advances by one on every strobe from upstream logic. It stops at all ones and never wraps.

The host sets an interrupt threshold by preloading a counter. Writing a value V leaves room for (all-ones − V) further events before saturation. The first event after saturation sets a sticky status flag. Six further alarm condition strobes set their own sticky flags. An 8-bit mask selects which flags may drive the single active-high interrupt line.

Access is through a small synchronous register port. Read data is registered and reading has no side effects, so the host can poll the counters at any time while they keep counting.

Top module: `alarm_counter_unit`

## Requirements
- R1: After synchronous reset, all three counters, the status register and the mask register are zero, `irq` is 0 and `reg_rdata` is 0.
- R2: Each counter increases by exactly one on each clock in which its own event strobe is high and its value is below all ones. The counters are independent of one another.
- R3: A counter at all ones (255 with the default width) stays at all ones on further events and never wraps.
- R4: A write to a counter address (0 = bipolar violations, 1 = framing/out-of-frame errors, 2 = errored superframes) loads the written value. A same-cycle event on that counter is dropped in favour of the write.
- R5: An event on the saturated bipolar-violation counter sets status bit 7. An event on the saturated framing counter or the saturated superframe counter sets status bit 6. An event that only brings a counter up to all ones sets no flag.
- R6: Condition strobe `cond_evt[k]` sets status bit k for k = 0..5. The meanings are: 5 yellow alarm, 4 carrier loss, 3 frame bit error, 2 zero-substitution detect, 1 blue alarm, 0 loss of sync.
- R7: Status bits are sticky. Writing to address 3 clears each bit written as 1 and leaves the others. A set in the same cycle as a clear wins.
- R8: The mask register is at address 4, and a mask bit of 1 enables that status bit. `irq` is registered: it equals the OR of (status AND mask) as it stood one clock earlier.
- R9: `reg_rdata` shows the register at the `reg_addr` presented one clock earlier. Addresses 5 to 7 read as 0, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bpv | input | 1 | Bipolar violation event strobe |
| ev_frm | input | 1 | Framing / out-of-frame error event strobe |
| ev_sf | input | 1 | Errored superframe event strobe |
| cond_evt | input | 6 | Alarm condition strobes for status bits 5..0 |
| reg_wr | input | 1 | Host write enable |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Active-high interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a host write colliding in the same clock with an event, either a preset racing an increment or a flag clear racing a saturation event. The second is the saturation flag itself, which would need hundreds of strobes from reset. The stimulus reaches saturation quickly by presetting a counter to just below all ones. It then drives event and write on the same negative edge, so both land on one rising edge. Read-back of the count and the status shows which side won.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int STAT_W   = 8;
    localparam int COND_W   = 6;
    localparam int NUM_CNT  = 3;
    localparam int ADDR_W   = 3;

    // Status bit positions fed by counter saturation overflow
    localparam int SB_BPV_SAT = 7;
    localparam int SB_ERR_SAT = 6;

    typedef enum logic [ADDR_W-1:0] {
        RA_BPV  = 3'd0,
        RA_FRM  = 3'd1,
        RA_SF   = 3'd2,
        RA_STAT = 3'd3,
        RA_MASK = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } host_req_t;

    function automatic logic hits(host_req_t req, reg_addr_e a);
        return req.wr && (req.addr == a);
    endfunction

endpackage

// File: rtl/alarm_sat_counter.sv
module alarm_sat_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          evt,
    output logic [DW-1:0] count,
    output logic          ovf_evt
);
    logic full;
    assign full    = &count;
    assign ovf_evt = evt && !load && full;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (evt && !full)
            count <= count + DW'(1);
    end
endmodule

// File: rtl/alarm_status_reg.sv
module alarm_status_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else
            stat <= (stat & ~clr) | set;
    end
endmodule

// File: rtl/alarm_counter_unit.sv
module alarm_counter_unit
    import alarm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_bpv,
    input  logic              ev_frm,
    input  logic              ev_sf,
    input  logic [COND_W-1:0] cond_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq
);
    localparam int RD_W = (DW > STAT_W) ? DW : STAT_W;

    host_req_t          req;
    logic [NUM_CNT-1:0] ev_vec;
    logic [NUM_CNT-1:0] ld_vec;
    logic [NUM_CNT-1:0] ovf_vec;
    logic [DW-1:0]      cnt_arr [NUM_CNT];
    logic [DW-1:0]      cnt_bpv, cnt_frm, cnt_sf;
    logic [STAT_W-1:0]  stat_set, stat_clr, stat_q, mask_q;
    logic [RD_W-1:0]    rd_next;

    assign req    = '{wr: reg_wr, addr: reg_addr};
    assign ev_vec = {ev_sf, ev_frm, ev_bpv};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign ld_vec[i] = hits(req, reg_addr_e'(i));
        alarm_sat_counter #(.DW(DW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (ld_vec[i]),
            .load_val (reg_wdata),
            .evt      (ev_vec[i]),
            .count    (cnt_arr[i]),
            .ovf_evt  (ovf_vec[i])
        );
    end

    assign cnt_bpv = cnt_arr[0];
    assign cnt_frm = cnt_arr[1];
    assign cnt_sf  = cnt_arr[2];

    always_comb begin
        stat_set             = '0;
        stat_set[COND_W-1:0] = cond_evt;
        stat_set[SB_BPV_SAT] = ovf_vec[0];
        stat_set[SB_ERR_SAT] = ovf_vec[1] | ovf_vec[2];
        stat_clr = hits(req, RA_STAT) ? reg_wdata[STAT_W-1:0] : '0;
    end

    alarm_status_reg #(.N(STAT_W)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .set  (stat_set),
        .clr  (stat_clr),
        .stat (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (hits(req, RA_MASK))
            mask_q <= reg_wdata[STAT_W-1:0];
    end

    always_comb begin
        rd_next = '0;
        case (reg_addr)
            RA_BPV:  rd_next = RD_W'(cnt_bpv);
            RA_FRM:  rd_next = RD_W'(cnt_frm);
            RA_SF:   rd_next = RD_W'(cnt_sf);
            RA_STAT: rd_next = RD_W'(stat_q);
            RA_MASK: rd_next = RD_W'(mask_q);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            reg_rdata <= rd_next[DW-1:0];
            irq       <= |(stat_q & mask_q);
        end
    end
endmodule

// File: rtl/alarm_counter_unit_chk.sv
module alarm_counter_unit_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_bpv,
    input logic          ev_frm,
    input logic          ev_sf,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] cnt_bpv,
    input logic [DW-1:0] cnt_frm,
    input logic [DW-1:0] cnt_sf,
    input logic [7:0]    stat_q,
    input logic [7:0]    mask_q,
    input logic          irq
);
    logic wr_bpv, wr_frm, wr_stat;
    logic [7:0] clr_bits;
    assign wr_bpv   = reg_wr && reg_addr == 3'd0;
    assign wr_frm   = reg_wr && reg_addr == 3'd1;
    assign wr_stat  = reg_wr && reg_addr == 3'd3;
    assign clr_bits = wr_stat ? reg_wdata[7:0] : 8'h00;

    // R2: without a preset the count moves by zero or one
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_bpv |=> (cnt_bpv == $past(cnt_bpv)) || (cnt_bpv == $past(cnt_bpv) + DW'(1)));

    // R3: saturated counter never wraps
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (&cnt_frm && !wr_frm) |=> &cnt_frm);

    // R4: preset wins over a same-cycle event
    p_preset_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_bpv && ev_bpv) |=> cnt_bpv == $past(reg_wdata));

    // R5: event on saturated counter raises its flag
    p_sat_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_bpv && &cnt_bpv && !wr_bpv) |=> stat_q[7]);

    p_err_flag_r5: assert property (@(posedge clk) disable iff (rst)
        ((ev_sf && &cnt_sf && !(reg_wr && reg_addr == 3'd2)) ||
         (ev_frm && &cnt_frm && !wr_frm)) |=> stat_q[6]);

    // R7: a set bit only falls when the host cleared it
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_q) & ~$past(clr_bits)) & ~stat_q) == 8'h00);

    // R8: interrupt follows masked status one clock later
    p_irq_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(|(stat_q & mask_q)));
endmodule

bind alarm_counter_unit alarm_counter_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_bpv    (ev_bpv),
    .ev_frm    (ev_frm),
    .ev_sf     (ev_sf),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_bpv   (cnt_bpv),
    .cnt_frm   (cnt_frm),
    .cnt_sf    (cnt_sf),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/alarm_counter_unit_bench.sv
module alarm_counter_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_bpv = 1'b0, ev_frm = 1'b0, ev_sf = 1'b0;
    logic [5:0] cond_evt = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] exp;
        int         due;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    alarm_counter_unit u_alarm_counter_unit (
        .clk(clk), .rst(rst), .ev_bpv(ev_bpv), .ev_frm(ev_frm), .ev_sf(ev_sf),
        .cond_evt(cond_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected read results once the registered data is due
    always @(negedge clk) begin
        if (sb_q.size() > 0 && cyc > sb_q[0].due) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, reg_rdata, it.exp);
        end
    end

    task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.exp = exp; it.due = cyc; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(int which, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ev_bpv = (which == 0); ev_frm = (which == 1); ev_sf = (which == 2);
            @(negedge clk);
            ev_bpv = 1'b0; ev_frm = 1'b0; ev_sf = 1'b0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(logic exp, string tag);
        idle(2);
        check(tag, {7'd0, irq}, {7'd0, exp});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, "R1 reset value");

        // R2: independent counting
        pulse(0, 3); pulse(1, 2); pulse(2, 1);
        rd(3'd0, 8'd3, "R2 bpv count");
        rd(3'd1, 8'd2, "R2 frm count");
        rd(3'd2, 8'd1, "R2 sf count");

        // R4 preset, R5 reaching max sets no flag
        wr(3'd0, 8'd253);
        rd(3'd0, 8'd253, "R4 preset value");
        pulse(0, 2);
        rd(3'd0, 8'd255, "R3 reach max");
        rd(3'd3, 8'h00, "R5 no flag at max");
        // R3 no wrap, R5 flag on next event
        pulse(0, 1);
        rd(3'd0, 8'd255, "R3 no wrap");
        rd(3'd3, 8'h80, "R5 bpv sat flag");
        chk_irq(1'b0, "R8 masked irq");

        // R8 enable
        wr(3'd4, 8'h80);
        rd(3'd4, 8'h80, "R8 mask readback");
        chk_irq(1'b1, "R8 irq enabled");

        // R7 clear
        wr(3'd3, 8'h80);
        rd(3'd3, 8'h00, "R7 clear");
        chk_irq(1'b0, "R8 irq drop");

        // R7 set wins over clear
        @(negedge clk);
        ev_bpv = 1'b1; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h80;
        @(negedge clk);
        ev_bpv = 1'b0; reg_wr = 1'b0;
        rd(3'd3, 8'h80, "R7 set beats clear");
        wr(3'd3, 8'hFF);

        // R4 write beats same-cycle event
        @(negedge clk);
        ev_frm = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'd10;
        @(negedge clk);
        ev_frm = 1'b0; reg_wr = 1'b0;
        rd(3'd1, 8'd10, "R4 preset beats event");

        // R5 bit 6 from superframe counter, then from framing counter
        wr(3'd2, 8'hFF);
        pulse(2, 1);
        rd(3'd3, 8'h40, "R5 sf sat flag");
        wr(3'd3, 8'h40);
        wr(3'd1, 8'hFF);
        pulse(1, 1);
        rd(3'd3, 8'h40, "R5 frm sat flag");
        wr(3'd3, 8'hFF);

        // R6 condition strobes, R8 mask blocking
        @(negedge clk); cond_evt = 6'b100001;
        @(negedge clk); cond_evt = 6'b000000;
        rd(3'd3, 8'h21, "R6 cond flags");
        wr(3'd4, 8'h02);
        chk_irq(1'b0, "R8 mask blocks");
        wr(3'd4, 8'h01);
        chk_irq(1'b1, "R8 bit0 enabled");
        @(negedge clk); cond_evt = 6'b011110;
        @(negedge clk); cond_evt = 6'b000000;
        rd(3'd3, 8'h3F, "R6 all cond flags");

        // R9 unused addresses and read side-effect free
        rd(3'd6, 8'h00, "R9 unused addr");
        rd(3'd1, 8'hFF, "R9 read no side effect");
        rd(3'd1, 8'hFF, "R9 reread");

        idle(4);
        done = 1;
        finish_run();
    end
endmodule